// File: doc/BRIEF.md
# I2C Bus Start/Stop Monitor

This block observes a shared two-wire bus without ever driving it. It resynchronizes the clock and data line levels into the local clock domain. It then recognizes the two framing conditions on the bus. A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. Two exclusive status bits record which of the two conditions was seen last.

A master on the same bus reads the bus-free output before it tries to take the bus. The bus counts as free when the last condition seen was a STOP, or when neither condition has been seen since reset or since the monitor was enabled. One interrupt flag is shared by three sources: START, STOP and a byte-complete strobe from a companion shift engine. A three-bit cause field records which of those sources set the flag. The flag and the cause bits stay set until a clear strobe arrives. The interrupt output is the flag qualified by an enable. So if the enable is set while the bus is busy, the following STOP raises the interrupt and announces that the bus is free.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, start_seen_o, stop_seen_o, irq_flag_o, irq_o and cause_o are all 0, and bus_free_o is 1.
- R2: A START (data line falling while the clock line is high) sets start_seen_o and clears stop_seen_o. The change appears within 4 clock cycles of the input change.
- R3: A STOP (data line rising while the clock line is high) sets stop_seen_o and clears start_seen_o. The change appears within 4 clock cycles of the input change.
- R4: A data line change while the clock line is low changes neither status bit and sets no interrupt or cause bit.
- R5: bus_free_o is 1 when stop_seen_o is 1 or when both status bits are 0. It is 0 while start_seen_o is 1.
- R6: irq_flag_o is set by a START, by a STOP, and by byte_done_i being high at a clock edge. Once set, it stays set until irq_clr_i is high at a clock edge.
- R7: cause_o records the sources of the flag: bit 0 is START, bit 1 is STOP and bit 2 is byte complete. The bits accumulate, and all of them clear with irq_clr_i.
- R8: When a flag source and irq_clr_i arrive at the same clock edge, the source wins. The flag and that source's cause bit are set after the edge.
- R9: irq_o equals irq_flag_o ANDed with irq_en_i. If the enable is set while the bus is busy and the flag is clear, the next STOP drives irq_o high.
- R10: While mon_en_i is low, both status bits, the flag and the cause bits are held at 0, and bus conditions and byte strobes are ignored.
- R11: A repeated START (a START while start_seen_o is already 1) keeps start_seen_o at 1 and sets the flag and cause bit 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en_i | input | 1 | Monitor enable; low clears and freezes the status |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| byte_done_i | input | 1 | One-cycle strobe from the shift engine when a byte completes |
| irq_en_i | input | 1 | Interrupt enable mask |
| irq_clr_i | input | 1 | Clears the flag and cause bits |
| start_seen_o | output | 1 | Last condition seen was a START |
| stop_seen_o | output | 1 | Last condition seen was a STOP |
| bus_free_o | output | 1 | Bus may be taken |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Masked interrupt request |
| cause_o | output | 3 | Sticky sources: [0] START, [1] STOP, [2] byte complete |

## Verification
A flag source and the clear strobe can land on the same clock edge. The flag can also be set by two sources together, such as a byte strobe and a STOP. The bench drives byte_done_i and irq_clr_i in the same cycle and checks that the flag and cause bit 2 survive. It then lets a START set the flag on top of the stored byte cause and checks that both cause bits remain. The checker adds a property that a byte strobe while enabled is followed by a set flag, whatever the clear input does.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int CAUSE_W     = 3;
  localparam int CAUSE_START = 0;
  localparam int CAUSE_STOP  = 1;
  localparam int CAUSE_BYTE  = 2;

  // START: data falls while clock is high in both samples
  function automatic logic is_start(input logic scl_now, input logic scl_prev,
                                    input logic sda_now, input logic sda_prev);
    return scl_now & scl_prev & sda_prev & ~sda_now;
  endfunction

  // STOP: data rises while clock is high in both samples
  function automatic logic is_stop(input logic scl_now, input logic scl_prev,
                                   input logic sda_now, input logic sda_prev);
    return scl_now & scl_prev & ~sda_prev & sda_now;
  endfunction

  function automatic logic free_of(input logic s_bit, input logic p_bit);
    return p_bit | (~s_bit & ~p_bit);
  endfunction
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '1;
          else        stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '1;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond
  import i2c_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_evt_o,
  output logic stop_evt_o
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s_i;
      sda_prev_q <= sda_s_i;
    end
  end

  assign start_evt_o = en_i & is_start(scl_s_i, scl_prev_q, sda_s_i, sda_prev_q);
  assign stop_evt_o  = en_i & is_stop(scl_s_i, scl_prev_q, sda_s_i, sda_prev_q);
endmodule

// File: rtl/i2c_mon_status.sv
module i2c_mon_status
  import i2c_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic start_evt_i,
  input  logic stop_evt_i,
  output logic s_o,
  output logic p_o,
  output logic free_o
);
  logic s_q, p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b0;
      p_q <= 1'b0;
    end else if (!en_i) begin
      s_q <= 1'b0;
      p_q <= 1'b0;
    end else if (start_evt_i) begin
      s_q <= 1'b1;
      p_q <= 1'b0;
    end else if (stop_evt_i) begin
      s_q <= 1'b0;
      p_q <= 1'b1;
    end
  end

  assign s_o    = s_q;
  assign p_o    = p_q;
  assign free_o = free_of(s_q, p_q);
endmodule

// File: rtl/i2c_mon_irq.sv
module i2c_mon_irq
  import i2c_mon_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [CAUSE_W-1:0] src_i,
  input  logic               clr_i,
  input  logic               mask_i,
  output logic               flag_o,
  output logic               irq_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q;

  generate
    for (genvar g = 0; g < CAUSE_W; g++) begin : g_cause
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cause_q[g] <= 1'b0;
        else if (!en_i)     cause_q[g] <= 1'b0;
        else if (src_i[g])  cause_q[g] <= 1'b1;
        else if (clr_i)     cause_q[g] <= 1'b0;
      end
    end
  endgenerate

  assign cause_o = cause_q;
  assign flag_o  = |cause_q;
  assign irq_o   = flag_o & mask_i;
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mon_en_i,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               byte_done_i,
  input  logic               irq_en_i,
  input  logic               irq_clr_i,
  output logic               start_seen_o,
  output logic               stop_seen_o,
  output logic               bus_free_o,
  output logic               irq_flag_o,
  output logic               irq_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [1:0] line_s;
  logic       start_evt, stop_evt, byte_evt;
  logic [CAUSE_W-1:0] src_vec;

  i2c_mon_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(line_s)
  );

  i2c_mon_cond u_cond (
    .clk(clk), .rst_n(rst_n), .en_i(mon_en_i),
    .scl_s_i(line_s[1]), .sda_s_i(line_s[0]),
    .start_evt_o(start_evt), .stop_evt_o(stop_evt)
  );

  i2c_mon_status u_status (
    .clk(clk), .rst_n(rst_n), .en_i(mon_en_i),
    .start_evt_i(start_evt), .stop_evt_i(stop_evt),
    .s_o(start_seen_o), .p_o(stop_seen_o), .free_o(bus_free_o)
  );

  assign byte_evt = mon_en_i & byte_done_i;

  always_comb begin
    src_vec              = '0;
    src_vec[CAUSE_START] = start_evt;
    src_vec[CAUSE_STOP]  = stop_evt;
    src_vec[CAUSE_BYTE]  = byte_evt;
  end

  i2c_mon_irq u_irq (
    .clk(clk), .rst_n(rst_n), .en_i(mon_en_i), .src_i(src_vec),
    .clr_i(irq_clr_i), .mask_i(irq_en_i),
    .flag_o(irq_flag_o), .irq_o(irq_o), .cause_o(cause_o)
  );
endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic start_evt,
  input logic stop_evt,
  input logic byte_done,
  input logic irq_en,
  input logic s_bit,
  input logic p_bit,
  input logic free,
  input logic flag,
  input logic irq,
  input logic clr
);
  // R2
  start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (s_bit && !p_bit));

  // R3
  stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (p_bit && !s_bit));

  // R5
  busy_not_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bit |-> !free);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr && en) |=> flag);

  // R8
  byte_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && en) |=> flag);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && flag));

  // R10
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!s_bit && !p_bit && !flag));
endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(mon_en_i),
  .start_evt(start_evt), .stop_evt(stop_evt), .byte_done(byte_done_i),
  .irq_en(irq_en_i), .s_bit(start_seen_o), .p_bit(stop_seen_o),
  .free(bus_free_o), .flag(irq_flag_o), .irq(irq_o), .clr(irq_clr_i)
);

// File: tb/i2c_bus_monitor_tb.sv
`timescale 1ns/1ps
module i2c_bus_monitor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, scl = 1'b1, sda = 1'b1, byte_done = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic s_o, p_o, free_o, flag_o, irq_o;
  logic [2:0] cause_o;
  int runs = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i2c_bus_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .mon_en_i(en), .scl_i(scl), .sda_i(sda),
    .byte_done_i(byte_done), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .start_seen_o(s_o), .stop_seen_o(p_o), .bus_free_o(free_o),
    .irq_flag_o(flag_o), .irq_o(irq_o), .cause_o(cause_o)
  );

  task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // each line change given 6 cycles to pass the synchronizer and register stages
  task automatic set_scl(input logic v); @(negedge clk); scl = v; cyc(6); endtask
  task automatic set_sda(input logic v); @(negedge clk); sda = v; cyc(6); endtask

  task automatic clear_irq;
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "start_seen", {3'b0, s_o}, 4'd0);
    check("R1", "stop_seen", {3'b0, p_o}, 4'd0);
    check("R1", "flag", {3'b0, flag_o}, 4'd0);
    check("R1", "irq", {3'b0, irq_o}, 4'd0);
    check("R1", "cause", {1'b0, cause_o}, 4'd0);
    check("R1", "bus_free", {3'b0, free_o}, 4'd1);
  endtask

  task automatic t_start;
    set_sda(1'b0);
    check("R2", "start_seen", {3'b0, s_o}, 4'd1);
    check("R2", "stop_seen", {3'b0, p_o}, 4'd0);
    check("R5", "bus_free busy", {3'b0, free_o}, 4'd0);
    check("R6", "flag on start", {3'b0, flag_o}, 4'd1);
    check("R7", "cause start", {1'b0, cause_o}, 4'b0001);
    clear_irq(); cyc(1);
    check("R6", "flag cleared", {3'b0, flag_o}, 4'd0);
    check("R7", "cause cleared", {1'b0, cause_o}, 4'd0);
  endtask

  task automatic t_low_clock;
    set_scl(1'b0); set_sda(1'b1); set_sda(1'b0); set_scl(1'b1);
    check("R4", "start_seen kept", {3'b0, s_o}, 4'd1);
    check("R4", "stop_seen kept", {3'b0, p_o}, 4'd0);
    check("R4", "no flag", {3'b0, flag_o}, 4'd0);
    check("R4", "no cause", {1'b0, cause_o}, 4'd0);
  endtask

  task automatic t_repeated_start;
    set_scl(1'b0); set_sda(1'b1); set_scl(1'b1); set_sda(1'b0);
    check("R11", "start_seen held", {3'b0, s_o}, 4'd1);
    check("R11", "flag again", {3'b0, flag_o}, 4'd1);
    check("R11", "cause start", {1'b0, cause_o}, 4'b0001);
    clear_irq();
  endtask

  task automatic t_enable_then_stop;
    @(negedge clk); irq_en = 1'b1; cyc(1);
    check("R9", "irq low while busy", {3'b0, irq_o}, 4'd0);
    set_scl(1'b0); set_scl(1'b1); set_sda(1'b1);
    check("R3", "stop_seen", {3'b0, p_o}, 4'd1);
    check("R3", "start_seen cleared", {3'b0, s_o}, 4'd0);
    check("R5", "bus_free after stop", {3'b0, free_o}, 4'd1);
    check("R9", "irq on stop", {3'b0, irq_o}, 4'd1);
    check("R7", "cause stop", {1'b0, cause_o}, 4'b0010);
    @(negedge clk); irq_en = 1'b0; cyc(1);
    check("R9", "irq masked", {3'b0, irq_o}, 4'd0);
    check("R9", "flag kept when masked", {3'b0, flag_o}, 4'd1);
    clear_irq();
  endtask

  task automatic t_byte_vs_clear;
    @(negedge clk); byte_done = 1'b1; irq_clr = 1'b1;
    @(negedge clk); byte_done = 1'b0; irq_clr = 1'b0;
    check("R8", "flag survives clear", {3'b0, flag_o}, 4'd1);
    check("R8", "byte cause survives", {1'b0, cause_o}, 4'b0100);
    set_sda(1'b0);
    check("R7", "causes accumulate", {1'b0, cause_o}, 4'b0101);
    clear_irq(); cyc(1);
    check("R6", "flag cleared", {3'b0, flag_o}, 4'd0);
  endtask

  task automatic t_disable;
    @(negedge clk); byte_done = 1'b1;
    @(negedge clk); byte_done = 1'b0; en = 1'b0; cyc(2);
    check("R10", "start_seen cleared", {3'b0, s_o}, 4'd0);
    check("R10", "stop_seen cleared", {3'b0, p_o}, 4'd0);
    check("R10", "flag cleared", {3'b0, flag_o}, 4'd0);
    check("R10", "cause cleared", {1'b0, cause_o}, 4'd0);
    check("R10", "bus_free idle", {3'b0, free_o}, 4'd1);
    set_scl(1'b0); set_scl(1'b1); set_sda(1'b1); set_sda(1'b0);
    @(negedge clk); byte_done = 1'b1;
    @(negedge clk); byte_done = 1'b0; cyc(1);
    check("R10", "start ignored", {3'b0, s_o}, 4'd0);
    check("R10", "events ignored", {3'b0, flag_o}, 4'd0);
    @(negedge clk); en = 1'b1; cyc(3);
    check("R10", "no event on re-enable", {1'b0, cause_o}, 4'd0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    @(negedge clk); en = 1'b1; cyc(8);
    t_start();
    t_low_clock();
    t_repeated_start();
    t_enable_then_stop();
    t_byte_vs_clear();
    t_disable();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      runs++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule